// File: doc/BRIEF.md
# Per-Lane Multiphase Sample Selector

This block deskews a source-synchronous parallel bus of one to eight data lanes by oversampling. Upstream capture logic samples every lane at eight evenly spaced points inside one source clock period: four phase-shifted sampling clocks, each used on both edges. It then hands the eight streams per lane to this block in one common clock domain. The block only sees those eight bits per lane per cycle. It has no knowledge of the clocks that produced them.

A calibration pulse starts a training pass. The sender then transmits a pseudo-random training sequence that follows the recurrence x[n] = x[n-7] XOR x[n-6]. For each lane, every one of the eight streams is checked against that recurrence on its own. Once training ends, the block looks at the set of error-free phases around the circle of eight. It picks the phase at the centre of the widest run and declares the lane locked if that run is wide enough. From then on, each lane forwards the bit taken at its own chosen phase. Lanes may therefore settle on different phases.

Top module: `mphase_deskew`

## Requirements
- R1: After reset, valid_o, every data_o bit, every lock_o bit and every phase_o field are 0.
- R2: A high cal_i drops valid_o on the next edge and starts training. While training, valid_o and data_o stay 0. Counting the edge that sampled cal_i as edge 0, valid_o first returns high after edge 265: 7 seed cycles, 256 compare cycles, one evaluation cycle and one output register.
- R3: A stream is error-free only if it seeds on the first 7 training samples with at least one 1 among them. After that, each of the next 256 samples must equal the sample 7 cycles back XOR the sample 6 cycles back. A single mismatch, or a seed of all zeros, marks that stream as erroneous.
- R4: A lane's chosen phase is (s + (L-1)/2) mod 8. Here s is the first phase and L the length of the longest run of error-free phases. Runs are circular, so a run may wrap from phase 7 to phase 0.
- R5: When several runs share the greatest length, the one whose centre index is lowest wins. When all eight phases are error-free, the chosen phase is 3.
- R6: lock_o for a lane goes high after training only if the longest run has at least 3 phases. Otherwise lock_o stays 0 and phase_o keeps the value it held before training.
- R7: Each lane's check, choice and lock depend only on that lane's eight streams.
- R8: While valid_o is high, data_o[l] equals the sample of lane l at its chosen phase p, taken from bit 8*l+p of samp_i on the previous clock edge. A lane that is not locked outputs 0.
- R9: The chosen phase of lane l appears at phase_o[3*l+2 : 3*l], and its lock flag at lock_o[l].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cal_i | input | 1 | Start (restart) training |
| samp_i | input | 8*NLANES | Eight phase samples per lane, lane l at bits 8*l+7 : 8*l, phase p at bit 8*l+p |
| data_o | output | NLANES | Deskewed data, one bit per lane |
| valid_o | output | 1 | High when data_o carries selected samples |
| lock_o | output | NLANES | Per-lane lock flag |
| phase_o | output | 3*NLANES | Per-lane chosen phase index |

## Verification
The bench goes after three kinds of window. First, windows that wrap from phase 7 to phase 0: a design with a linear search would split them and centre on the wrong half. Second, two runs of equal length, where picking by start index rather than centre index gives a different phase. Third, the fully clean lane, which a naive circular search centres at 0 rather than 3. It also injects single bit errors anywhere in the compare window, plus all-zero streams that satisfy the recurrence trivially. Failing lanes are placed after a locked pass, so a design that resets the phase instead of holding it is exposed. The cycle count of the training pass is also checked, so an off-by-one in the seed or compare length shows as a valid_o that rises one cycle early or late.

// File: rtl/mds_pkg.sv
package mds_pkg;
  localparam int unsigned NPH = 8;
  localparam int unsigned PW  = $clog2(NPH);

  typedef struct packed {
    logic [PW:0]   len;
    logic [PW-1:0] ctr;
  } win_t;

  // Longest circular run of ones in ok; centre index, lowest centre on ties.
  function automatic win_t pick_window(input logic [NPH-1:0] ok);
    win_t best;
    int   run_len;
    int   ctr;
    bit   going;
    best = '0;
    if (&ok) begin
      best.len = (PW+1)'(NPH);
      best.ctr = PW'((NPH - 1) / 2);
    end else begin
      for (int s = 0; s < NPH; s++) begin
        if (ok[s] && !ok[(s + NPH - 1) % NPH]) begin
          run_len = 0;
          going   = 1'b1;
          for (int i = 0; i < NPH; i++) begin
            if (going && ok[(s + i) % NPH]) run_len++;
            else going = 1'b0;
          end
          ctr = (s + (run_len - 1) / 2) % NPH;
          if (run_len > int'(best.len) ||
              (run_len == int'(best.len) && ctr < int'(best.ctr))) begin
            best.len = (PW+1)'(run_len);
            best.ctr = PW'(ctr);
          end
        end
      end
    end
    return best;
  endfunction
endpackage

// File: rtl/mds_prbs_chk.sv
module mds_prbs_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_en_i,
  input  logic cmp_en_i,
  input  logic bit_i,
  output logic err_o
);
  logic [6:0] hist_q, hist_d;
  logic       err_q, err_d;
  logic       predict;

  assign predict = hist_q[6] ^ hist_q[5];

  always_comb begin
    hist_d = hist_q;
    err_d  = err_q;
    if (clr_i) begin
      err_d = 1'b0;
    end else if (shift_en_i) begin
      hist_d = {hist_q[5:0], bit_i};
      if (cmp_en_i && ((bit_i != predict) || (hist_q == '0))) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      err_q  <= 1'b1;
    end else begin
      hist_q <= hist_d;
      err_q  <= err_d;
    end
  end

  assign err_o = err_q;

  // R3: an error flag stays set until a new training pass clears it
  a_r3_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/mds_ctrl.sv
module mds_ctrl #(
  parameter int unsigned SEED = 7,
  parameter int unsigned NCMP = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cal_i,
  output logic train_o,
  output logic cmp_o,
  output logic eval_o,
  output logic run_o
);
  localparam int unsigned LAST = SEED + NCMP - 1;
  localparam int unsigned CW   = $clog2(LAST + 1);

  typedef enum logic [1:0] {S_IDLE, S_TRAIN, S_EVAL, S_RUN} state_e;

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cal_i) begin
      state_d = S_TRAIN;
      cnt_d   = '0;
    end else begin
      case (state_q)
        S_TRAIN: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(LAST)) state_d = S_EVAL;
        end
        S_EVAL:  state_d = S_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign train_o = (state_q == S_TRAIN);
  assign cmp_o   = train_o && (cnt_q >= CW'(SEED));
  assign eval_o  = (state_q == S_EVAL);
  assign run_o   = (state_q == S_RUN);

  // R2: evaluation follows only the last compare cycle
  a_r2_eval_after_train: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_o && !$past(cal_i)) |-> $past(train_o));
endmodule

// File: rtl/mds_lane.sv
module mds_lane
  import mds_pkg::*;
#(
  parameter int unsigned MIN_WIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cal_i,
  input  logic           train_i,
  input  logic           cmp_i,
  input  logic           eval_i,
  input  logic           run_i,
  input  logic [NPH-1:0] samp_i,
  output logic           data_o,
  output logic           lock_o,
  output logic [PW-1:0]  phase_o
);
  logic [NPH-1:0] err;
  win_t           win;
  logic           win_ok;
  logic           lock_q, lock_d;
  logic [PW-1:0]  phase_q, phase_d;
  logic           data_q, data_d;

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    mds_prbs_chk u_chk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (cal_i),
      .shift_en_i (train_i),
      .cmp_en_i   (cmp_i),
      .bit_i      (samp_i[p]),
      .err_o      (err[p])
    );
  end

  assign win    = pick_window(~err);
  assign win_ok = (win.len >= (PW+1)'(MIN_WIN));

  always_comb begin
    lock_d  = lock_q;
    phase_d = phase_q;
    if (cal_i) begin
      lock_d = 1'b0;
    end else if (eval_i) begin
      lock_d = win_ok;
      if (win_ok) phase_d = win.ctr;
    end
    data_d = (run_i && !cal_i && lock_q) ? samp_i[phase_q] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      phase_q <= '0;
      data_q  <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      phase_q <= phase_d;
      data_q  <= data_d;
    end
  end

  assign data_o  = data_q;
  assign lock_o  = lock_q;
  assign phase_o = phase_q;

  // R6: a locked lane has at least MIN_WIN clean phases
  a_r6_lock_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> ($countones(~err) >= MIN_WIN));
  // R4: a locked lane never sits on an erroneous phase
  a_r4_clean_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !err[phase_q]);
  // R6: failed evaluation leaves the phase alone
  a_r6_hold_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !cal_i && !win_ok) |=> $stable(phase_q));
  // R8: unlocked lane outputs zero
  a_r8_unlocked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> !data_q);
endmodule

// File: rtl/mphase_deskew.sv
module mphase_deskew
  import mds_pkg::*;
#(
  parameter int unsigned NLANES  = 8,
  parameter int unsigned NCMP    = 256,
  parameter int unsigned MIN_WIN = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cal_i,
  input  logic [NLANES*NPH-1:0] samp_i,
  output logic [NLANES-1:0]    data_o,
  output logic                 valid_o,
  output logic [NLANES-1:0]    lock_o,
  output logic [NLANES*PW-1:0] phase_o
);
  localparam int unsigned SEED = 7;

  logic train, cmp, eval, run;
  logic valid_q, valid_d;

  mds_ctrl #(.SEED(SEED), .NCMP(NCMP)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cal_i   (cal_i),
    .train_o (train),
    .cmp_o   (cmp),
    .eval_o  (eval),
    .run_o   (run)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    mds_lane #(.MIN_WIN(MIN_WIN)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cal_i   (cal_i),
      .train_i (train),
      .cmp_i   (cmp),
      .eval_i  (eval),
      .run_i   (run),
      .samp_i  (samp_i[l*NPH +: NPH]),
      .data_o  (data_o[l]),
      .lock_o  (lock_o[l]),
      .phase_o (phase_o[l*PW +: PW])
    );
  end

  assign valid_d = run && !cal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  assign valid_o = valid_q;

  // R2: calibration request removes valid on the next edge
  a_r2_cal_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_i |=> !valid_o);
  // R2: data is quiet whenever it is not valid
  a_r2_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0));
  // R6: lock never appears during training
  a_r6_no_lock_in_train: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train |-> (lock_o == '0));
endmodule

// File: tb/mphase_deskew_tb.sv
`timescale 1ns/1ps
module mphase_deskew_tb;
  localparam int NL = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            cal_i;
  logic [NL*8-1:0] samp_i;
  logic [NL-1:0]   data_o;
  logic            valid_o;
  logic [NL-1:0]   lock_o;
  logic [NL*3-1:0] phase_o;

  always #2.5 clk_i = ~clk_i;

  mphase_deskew u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cal_i(cal_i), .samp_i(samp_i),
    .data_o(data_o), .valid_o(valid_o), .lock_o(lock_o), .phase_o(phase_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  int  exp_ph [NL];
  bit  exp_lk [NL];
  bit  prbs [0:299];
  logic [7:0] okm [NL];
  int  epos [NL][8];
  bit  zer  [NL][8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Widest circular window from the requirements (R4, R5)
  function automatic void exp_pick(input logic [7:0] ok, output int c, output int w);
    w = 0; c = 0;
    if (ok == 8'hFF) begin w = 8; c = 3; return; end
    for (int ww = 8; ww >= 1; ww--) begin
      if (w == 0) begin
        for (int s = 0; s < 8; s++) begin
          bit all = 1'b1;
          for (int i = 0; i < ww; i++) if (!ok[(s + i) % 8]) all = 1'b0;
          if (all && (w == 0 || ((s + (ww - 1) / 2) % 8) < c)) begin
            w = ww;
            c = (s + (ww - 1) / 2) % 8;
          end
        end
      end
    end
  endfunction

  function automatic bit stream_bit(input int l, input int p, input int k);
    if (okm[l][p]) return prbs[k];
    if (zer[l][p]) return 1'b0;
    return prbs[k] ^ (k == epos[l][p]);
  endfunction

  task automatic gen_prbs();
    int seed;
    seed = int'($urandom % 127) + 1;
    for (int i = 0; i < 7; i++) prbs[i] = seed[i];
    for (int n = 7; n < 300; n++) prbs[n] = prbs[n-7] ^ prbs[n-6];
  endtask

  task automatic set_bad_kinds();
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < 8; p++) begin
        zer[l][p]  = (($urandom % 4) == 0);
        epos[l][p] = 7 + int'($urandom % 256);
      end
  endtask

  task automatic do_train(input string tag);
    int  quiet_bad;
    int  c, w;
    logic [NL*8-1:0] prev;
    gen_prbs();
    set_bad_kinds();
    for (int l = 0; l < NL; l++) begin
      exp_pick(okm[l], c, w);
      if (w >= 3) begin exp_lk[l] = 1'b1; exp_ph[l] = c; end
      else exp_lk[l] = 1'b0;
    end
    @(negedge clk_i);
    cal_i  = 1'b1;
    samp_i = {$urandom, $urandom};
    @(negedge clk_i);
    cal_i = 1'b0;
    quiet_bad = 0;
    for (int k = 0; k <= 265; k++) begin
      if (k <= 264) begin
        if (valid_o !== 1'b0 || data_o !== '0) quiet_bad++;
      end else begin
        chk(valid_o === 1'b1, "R2", {tag, " valid after edge 265"}, valid_o, 1);
      end
      if (k < 263) begin
        for (int l = 0; l < NL; l++)
          for (int p = 0; p < 8; p++) samp_i[l*8 + p] = stream_bit(l, p, k);
      end else begin
        samp_i = {$urandom, $urandom};
      end
      if (k < 265) @(negedge clk_i);
    end
    chk(quiet_bad == 0, "R2", {tag, " outputs quiet in training"}, quiet_bad, 0);
    for (int l = 0; l < NL; l++) begin
      chk(lock_o[l] === exp_lk[l], "R6 R7 R9", $sformatf("%s lane %0d lock mask %h", tag, l, okm[l]),
          lock_o[l], exp_lk[l]);
      chk(int'(phase_o[l*3 +: 3]) == exp_ph[l], "R4 R5 R9",
          $sformatf("%s lane %0d phase mask %h", tag, l, okm[l]), phase_o[l*3 +: 3], exp_ph[l]);
    end
    for (int j = 0; j < 16; j++) begin
      logic [NL-1:0] e;
      prev = samp_i;
      @(negedge clk_i);
      for (int l = 0; l < NL; l++) e[l] = exp_lk[l] ? prev[l*8 + exp_ph[l]] : 1'b0;
      chk(data_o === e && valid_o === 1'b1, "R8", {tag, " selected data"}, data_o, e);
      samp_i = {$urandom, $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0;
    cal_i  = 1'b0;
    samp_i = '0;
    for (int l = 0; l < NL; l++) begin exp_ph[l] = 0; exp_lk[l] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk(valid_o === 1'b0, "R1", "valid", valid_o, 0);
    chk(data_o === '0, "R1", "data", data_o, 0);
    chk(lock_o === '0, "R1", "lock", lock_o, 0);
    chk(phase_o === '0, "R1", "phase", phase_o, 0);

    // R5: all clean lanes centre on phase 3
    for (int l = 0; l < NL; l++) okm[l] = 8'hFF;
    do_train("all_clean");

    // Directed windows: wrap (R4), tie (R5), narrow/failed with hold (R6), R3 injected errors
    okm[0] = 8'hFF; okm[1] = 8'hC3; okm[2] = 8'hEE; okm[3] = 8'h06;
    okm[4] = 8'h00; okm[5] = 8'h7C; okm[6] = 8'h01; okm[7] = 8'hF0;
    do_train("directed");

    // Wrap and tie variants on other lanes (R4, R5, R7)
    okm[0] = 8'h8F; okm[1] = 8'h77; okm[2] = 8'hBB; okm[3] = 8'h07;
    okm[4] = 8'hE1; okm[5] = 8'h03; okm[6] = 8'h18; okm[7] = 8'hDE;
    do_train("wrap_tie");

    // Random masks per lane (R3, R4, R5, R6, R7, R8)
    for (int r = 0; r < 9; r++) begin
      for (int l = 0; l < NL; l++) okm[l] = 8'($urandom);
      do_train($sformatf("rand%0d", r));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule